// File: doc/BRIEF.md
# CPU-synchronous SDRAM fast-memory controller

This block puts a single SDRAM array on the local bus of a 32-bit processor as fast memory. It runs on the processor clock, and every handshake is sampled and driven on that clock. When the address strobe is asserted with an address inside a configurable decode window, the controller runs one closed-page SDRAM transaction: row activate, a single column read or write, then precharge of that bank. It ends the bus cycle by pulling a synchronous termination strobe low for exactly two clocks. Asynchronous acknowledge handshaking is not used.

A read always fetches a whole 32-bit longword and presents all four bytes unchanged. The processor selects the byte lanes it asked for. A write drives the SDRAM byte masks from the transfer size and the low address bits, so only the addressed bytes change. The window may be larger than the installed memory. Such cycles never reach the main system bus, so for an address in the window but above the populated size the controller raises bus error itself. After reset the controller runs the SDRAM power-up sequence. It then issues auto-refresh at a fixed interval, always from idle, and any processor access that arrives meanwhile waits for the refresh to finish.

Top module: `fmem_sdram_ctrl`

## Requirements
- R1: After reset, no SDRAM command is issued for INIT_CYC clocks and clock enable stays low during reset. The first four commands are then: precharge-all (address bit 10 set), auto-refresh, auto-refresh, and mode-register load with address value 0x020 (burst length 1, CAS latency 2). Every row activate comes after the mode-register load.
- R2: A read returns the full stored longword whatever the size code and low address bits. All four byte masks are zero on every read command. The data is valid on `cpu_rdata` while `cpu_sterm_n` is low.
- R3: Size code 00 means 4 bytes, 01 means 1, 10 means 2 and 11 means 3. A write covers the bytes from offset addr[1:0] up to offset+size-1, clipped at offset 3. Offset 0 is data bits 31:24, and `sd_dqm[3-k]` masks offset k. Only the covered bytes of the longword change.
- R4: Each access to populated memory drives `cpu_sterm_n` low for exactly two consecutive clocks and then high again. Outside an access it stays high, including during reset.
- R5: An access inside the window but at or above the populated size (2^(ROW_W+BANK_W+COL_W+2) bytes above the window base) drives `cpu_berr_n` low and holds it until the address strobe is released. It issues no SDRAM command and never asserts `cpu_sterm_n`.
- R6: An address strobe with an address outside the window (upper ADDR_W-WIN_BITS bits differ from WIN_BASE) produces no activate, no termination and no bus error.
- R7: The longword index addr[POP-1:2] splits, from low to high, into column (COL_W bits), bank (BANK_W bits) and row (ROW_W bits). Every access activates its row and issues one column command. It then precharges that bank before any other activate or refresh, so no row is ever left open.
- R8: An auto-refresh is issued once every REF_INT clocks, served from idle only, with no row open. Accesses that arrive meanwhile complete correctly after it.
- R9: One assertion of the address strobe produces one transaction. Holding the strobe low after termination starts no second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, shared by bus and SDRAM |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_siz | input | 2 | Transfer size code (00=4, 01=1, 10=2, 11=3 bytes) |
| cpu_wdata | input | 32 | Write data, already placed on its byte lanes |
| cpu_rdata | output | 32 | Full longword read data |
| cpu_sterm_n | output | 1 | Synchronous termination, active low, two clocks |
| cpu_berr_n | output | 1 | Bus error for unpopulated window addresses, active low |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | BANK_W | SDRAM bank address |
| sd_a | output | SDA_W | SDRAM multiplexed address |
| sd_dqm | output | 4 | SDRAM byte masks, active high, bit 3 = data bits 31:24 |
| sd_dq_o | output | 32 | SDRAM write data |
| sd_dq_oe | output | 1 | SDRAM data output enable |
| sd_dq_i | input | 32 | SDRAM read data |

## Verification
The bench builds the controller with a 3-bit row, one bank bit and a 4-bit column, so the array holds 256 longwords. Every location is written and read back, and the bench's SDRAM model is compared with an arithmetic reference, which also shows whether row, bank and column land in the right places. The window is 4 KB with 1 KB populated, which puts both edges of the bus-error region and addresses just outside the window within a few accesses. A power-up wait of 50 clocks and a refresh interval of 64 clocks mean that the whole start-up sequence and many refreshes happen during the run, several of them colliding with processor accesses. Every offset and size code is swept over the byte-mask writes.

// File: rtl/fmem_pkg.sv
package fmem_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    S_PWR, S_IPRE, S_IREF1, S_IREF2, S_IMRS,
    S_IDLE, S_ACT, S_RD, S_WR, S_TERM1, S_TERM2, S_DONE,
    S_REF, S_BERR
  } fsm_e;

  localparam int CAS_LAT = 2;

endpackage

// File: rtl/fmem_addr_map.sv
module fmem_addr_map #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0800_0000,
  parameter int                WIN_BITS = 27,
  parameter int                ROW_W    = 13,
  parameter int                BANK_W   = 2,
  parameter int                COL_W    = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        siz,
  output logic              in_win,
  output logic              populated,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col,
  output logic [3:0]        byte_mask
);
  localparam int LW_W     = COL_W + BANK_W + ROW_W;
  localparam int POP_BITS = LW_W + 2;

  logic [LW_W-1:0] lw;
  logic [2:0]      first_b;
  logic [2:0]      span;
  logic [2:0]      stop_b;

  assign lw     = addr[POP_BITS-1:2];
  assign col    = lw[COL_W-1:0];
  assign bank   = lw[COL_W +: BANK_W];
  assign row    = lw[COL_W+BANK_W +: ROW_W];
  assign in_win = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

  generate
    if (WIN_BITS > POP_BITS) begin : g_partial
      assign populated = ~|addr[WIN_BITS-1:POP_BITS];
    end else begin : g_full
      assign populated = 1'b1;
    end
  endgenerate

  // Mask bit 3-k covers byte offset k (offset 0 = bits 31:24).
  always_comb begin
    first_b = {1'b0, addr[1:0]};
    span    = (siz == 2'b00) ? 3'd4 : {1'b0, siz};
    stop_b  = first_b + span;
    for (int k = 0; k < 4; k++) begin
      byte_mask[3-k] = !((3'(k) >= first_b) && (3'(k) < stop_b));
    end
  end

endmodule

// File: rtl/fmem_refresh_tmr.sv
module fmem_refresh_tmr #(
  parameter int REF_INT = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int CNT_W = $clog2(REF_INT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (cnt == CNT_W'(REF_INT - 1)) begin
      cnt     <= '0;
      pending <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (ack) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/fmem_sdram_ctrl.sv
module fmem_sdram_ctrl
  import fmem_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0800_0000,
  parameter int                WIN_BITS = 27,
  parameter int                ROW_W    = 13,
  parameter int                BANK_W   = 2,
  parameter int                COL_W    = 9,
  parameter int                SDA_W    = 13,
  parameter int                INIT_CYC = 10000,
  parameter int                REF_INT  = 780,
  parameter int                T_RCD    = 2,
  parameter int                T_RP     = 2,
  parameter int                T_RFC    = 7,
  parameter int                T_MRD    = 2,
  parameter int                T_WR     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_as_n,
  input  logic              cpu_rw,
  input  logic [1:0]        cpu_siz,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_sterm_n,
  output logic              cpu_berr_n,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [SDA_W-1:0]  sd_a,
  output logic [3:0]        sd_dqm,
  output logic [31:0]       sd_dq_o,
  output logic              sd_dq_oe,
  input  logic [31:0]       sd_dq_i
);
  localparam int DLY_W = $clog2(T_RFC + T_RP + T_RCD + T_WR + T_MRD + CAS_LAT + 1);
  localparam int PWR_W = $clog2(INIT_CYC + 1);
  localparam logic [SDA_W-1:0] MODE_WORD = SDA_W'(32'h20);  // BL1, sequential, CL2
  localparam logic [SDA_W-1:0] ALL_BANKS = SDA_W'(32'h400); // A10

  logic              m_in_win, m_pop;
  logic [ROW_W-1:0]  m_row;
  logic [BANK_W-1:0] m_bank;
  logic [COL_W-1:0]  m_col;
  logic [3:0]        m_mask;
  logic              ref_pend, ref_ack;

  fsm_e              state;
  sd_cmd_e           cmd_q;
  logic [DLY_W-1:0]  dly;
  logic [PWR_W-1:0]  pwr_cnt;
  logic [COL_W-1:0]  col_q;
  logic [3:0]        mask_q;
  logic [31:0]       wdata_q;
  logic              rd_q;

  fmem_addr_map #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS),
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)
  ) u_map (
    .addr(cpu_addr), .siz(cpu_siz), .in_win(m_in_win), .populated(m_pop),
    .row(m_row), .bank(m_bank), .col(m_col), .byte_mask(m_mask)
  );

  fmem_refresh_tmr #(.REF_INT(REF_INT)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_PWR;
      cmd_q       <= CMD_NOP;
      dly         <= '0;
      pwr_cnt     <= '0;
      col_q       <= '0;
      mask_q      <= '1;
      wdata_q     <= '0;
      rd_q        <= 1'b1;
      cpu_rdata   <= '0;
      cpu_sterm_n <= 1'b1;
      cpu_berr_n  <= 1'b1;
      sd_cke      <= 1'b0;
      sd_cs_n     <= 1'b1;
      sd_ba       <= '0;
      sd_a        <= '0;
      sd_dqm      <= '1;
      sd_dq_o     <= '0;
      sd_dq_oe    <= 1'b0;
      ref_ack     <= 1'b0;
    end else begin
      cmd_q    <= CMD_NOP;
      sd_dq_oe <= 1'b0;
      ref_ack  <= 1'b0;
      sd_cke   <= 1'b1;
      sd_cs_n  <= 1'b0;
      case (state)
        S_PWR: begin
          if (pwr_cnt == PWR_W'(INIT_CYC - 1)) begin
            cmd_q <= CMD_PRE;
            sd_a  <= ALL_BANKS;
            dly   <= DLY_W'(T_RP - 1);
            state <= S_IPRE;
          end else begin
            pwr_cnt <= pwr_cnt + 1'b1;
          end
        end
        S_IPRE, S_IREF1: begin
          if (dly != '0) dly <= dly - 1'b1;
          else begin
            cmd_q <= CMD_REF;
            dly   <= DLY_W'(T_RFC - 1);
            state <= (state == S_IPRE) ? S_IREF1 : S_IREF2;
          end
        end
        S_IREF2: begin
          if (dly != '0) dly <= dly - 1'b1;
          else begin
            cmd_q <= CMD_MRS;
            sd_a  <= MODE_WORD;
            dly   <= DLY_W'(T_MRD - 1);
            state <= S_IMRS;
          end
        end
        S_IMRS, S_REF: begin
          if (dly != '0) dly <= dly - 1'b1;
          else state <= S_IDLE;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cmd_q   <= CMD_REF;
            ref_ack <= 1'b1;
            dly     <= DLY_W'(T_RFC - 1);
            state   <= S_REF;
          end else if (!cpu_as_n && m_in_win) begin
            if (!m_pop) begin
              cpu_berr_n <= 1'b0;
              state      <= S_BERR;
            end else begin
              cmd_q   <= CMD_ACT;
              sd_ba   <= m_bank;
              sd_a    <= SDA_W'(m_row);
              col_q   <= m_col;
              mask_q  <= m_mask;
              wdata_q <= cpu_wdata;
              rd_q    <= cpu_rw;
              dly     <= DLY_W'(T_RCD - 1);
              state   <= S_ACT;
            end
          end
        end
        S_ACT: begin
          if (dly != '0) dly <= dly - 1'b1;
          else begin
            sd_a <= SDA_W'(col_q);
            if (rd_q) begin
              cmd_q  <= CMD_RD;
              sd_dqm <= 4'b0000;
              dly    <= DLY_W'(CAS_LAT);
              state  <= S_RD;
            end else begin
              cmd_q    <= CMD_WR;
              sd_dqm   <= mask_q;
              sd_dq_o  <= wdata_q;
              sd_dq_oe <= 1'b1;
              dly      <= DLY_W'(T_WR);
              state    <= S_WR;
            end
          end
        end
        S_RD, S_WR: begin
          if (dly != '0) dly <= dly - 1'b1;
          else begin
            if (state == S_RD) cpu_rdata <= sd_dq_i;
            cmd_q       <= CMD_PRE;
            sd_a        <= '0;
            cpu_sterm_n <= 1'b0;
            dly         <= DLY_W'(T_RP - 1);
            state       <= S_TERM1;
          end
        end
        S_TERM1: begin
          if (dly != '0) dly <= dly - 1'b1;
          state <= S_TERM2;
        end
        S_TERM2: begin
          if (dly != '0) dly <= dly - 1'b1;
          cpu_sterm_n <= 1'b1;
          state       <= S_DONE;
        end
        S_DONE: begin
          if (dly != '0) dly <= dly - 1'b1;
          else if (cpu_as_n) state <= S_IDLE;
        end
        S_BERR: begin
          if (cpu_as_n) begin
            cpu_berr_n <= 1'b1;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fmem_sdram_ctrl_chk.sv
module fmem_sdram_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_as_n,
  input logic       cpu_sterm_n,
  input logic       cpu_berr_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic [3:0] sd_dqm,
  input logic       sd_dq_oe
);
  logic is_rd, is_wr, is_nop;
  assign is_rd  = sd_ras_n && !sd_cas_n && sd_we_n;
  assign is_wr  = sd_ras_n && !sd_cas_n && !sd_we_n;
  assign is_nop = sd_ras_n && sd_cas_n && sd_we_n;

  AST_STERM_HOLDS_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_sterm_n) |=> !cpu_sterm_n);                                     // R4
  AST_STERM_ENDS_AFTER_TWO: assert property (@(posedge clk) disable iff (rst)
    (!cpu_sterm_n && !$past(cpu_sterm_n)) |=> cpu_sterm_n);                   // R4
  AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> (sd_dqm == 4'b0000));                                           // R2
  AST_READ_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> !sd_dq_oe);                                                     // R2
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    is_wr |-> sd_dq_oe);                                                      // R3
  AST_BERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!cpu_berr_n && !cpu_sterm_n));                                          // R5
  AST_BERR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cpu_berr_n && !cpu_as_n) |=> !cpu_berr_n);                              // R5
  AST_BERR_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    !cpu_berr_n |-> is_nop);                                                  // R5

endmodule

bind fmem_sdram_ctrl fmem_sdram_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_as_n(cpu_as_n), .cpu_sterm_n(cpu_sterm_n),
  .cpu_berr_n(cpu_berr_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_dq_oe(sd_dq_oe)
);

// File: tb/fmem_sdram_ctrl_bench.sv
`timescale 1ns/1ps
module fmem_sdram_ctrl_bench;
  localparam int ROW_W = 3, BANK_W = 1, COL_W = 4, SDA_W = 11;
  localparam int INIT = 50, RINT = 64;
  localparam logic [31:0] BASE = 32'h0100_0000;
  localparam int NLW = 1 << (ROW_W + BANK_W + COL_W);

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] addr = '0, wdata = '0, rdata;
  logic as_n = 1'b1, rw = 1'b1;
  logic [1:0] siz = 2'b00;
  logic sterm_n, berr_n, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BANK_W-1:0] sd_ba;
  logic [SDA_W-1:0]  sd_a;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_o;
  logic [31:0] sd_dq_i = '0;

  fmem_sdram_ctrl #(
    .WIN_BASE(BASE), .WIN_BITS(12), .ROW_W(ROW_W), .BANK_W(BANK_W),
    .COL_W(COL_W), .SDA_W(SDA_W), .INIT_CYC(INIT), .REF_INT(RINT)
  ) u_fmem_sdram_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_as_n(as_n), .cpu_rw(rw),
    .cpu_siz(siz), .cpu_wdata(wdata), .cpu_rdata(rdata),
    .cpu_sterm_n(sterm_n), .cpu_berr_n(berr_n), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
  );

  // ---------------- SDRAM model and command log ----------------
  logic [31:0] mem [NLW];
  logic [31:0] ref_mem [NLW];
  logic [ROW_W-1:0] rowq [1 << BANK_W];
  logic open_b [1 << BANK_W];
  logic [31:0] pipe_q = '0;
  logic [2:0] h_cmd [4];
  logic [SDA_W-1:0] h_a [4];
  int ncmd = 0, first_cyc = -1, cyc = 0;
  int n_act = 0, n_ref = 0, proto_err = 0;
  bit mrs_seen = 0;
  logic [2:0] mc;
  logic [ROW_W+BANK_W+COL_W-1:0] m_idx;
  assign mc    = {sd_ras_n, sd_cas_n, sd_we_n};
  assign m_idx = {rowq[sd_ba], sd_ba, sd_a[COL_W-1:0]};

  initial begin
    for (int i = 0; i < NLW; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    for (int b = 0; b < (1 << BANK_W); b++) begin open_b[b] = 1'b0; rowq[b] = '0; end
  end

  always @(posedge clk) begin
    sd_dq_i <= pipe_q;
    pipe_q  <= 32'hDEAD_BEEF;
    if (!rst) begin
      cyc <= cyc + 1;
      if (!sd_cs_n && sd_cke && mc != 3'b111) begin
        if (ncmd < 4) begin
          h_cmd[ncmd] <= mc;
          h_a[ncmd]   <= sd_a;
          if (ncmd == 0) first_cyc <= cyc;
          ncmd <= ncmd + 1;
        end
        case (mc)
          3'b011: begin
            if (open_b[sd_ba] || !mrs_seen) proto_err <= proto_err + 1;
            open_b[sd_ba] <= 1'b1;
            rowq[sd_ba]   <= sd_a[ROW_W-1:0];
            n_act <= n_act + 1;
          end
          3'b101: begin
            if (!open_b[sd_ba]) proto_err <= proto_err + 1;
            pipe_q <= mem[m_idx];
          end
          3'b100: begin
            if (!open_b[sd_ba] || !sd_dq_oe) proto_err <= proto_err + 1;
            for (int k = 0; k < 4; k++)
              if (!sd_dqm[3-k]) mem[m_idx][31-8*k -: 8] <= sd_dq_o[31-8*k -: 8];
          end
          3'b010: begin
            if (sd_a[10]) begin
              for (int b = 0; b < (1 << BANK_W); b++) open_b[b] <= 1'b0;
            end else open_b[sd_ba] <= 1'b0;
          end
          3'b001: begin
            for (int b = 0; b < (1 << BANK_W); b++) if (open_b[b]) proto_err <= proto_err + 1;
            n_ref <= n_ref + 1;
          end
          3'b000: mrs_seen <= 1'b1;
          default: proto_err <= proto_err + 1;
        endcase
      end
    end
  end

  // termination strobe falls, sampled mid-cycle
  int st_falls = 0;
  logic st_prev = 1'b1;
  always @(negedge clk) begin
    if (!rst && !sterm_n && st_prev) st_falls = st_falls + 1;
    st_prev = sterm_n;
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'h9E37_79B9 * 32'(i)) ^ (32'h0F0F_1234 + 32'(salt));
  endfunction

  task automatic access(input logic [31:0] a, input logic rd, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rv,
                        output int lows, output bit be);
    bit done;
    done = 0; lows = 0; be = 0; rv = '0;
    @(negedge clk);
    addr = a; rw = rd; siz = sz; wdata = wd; as_n = 1'b0;
    for (int k = 0; k < 300 && !done; k++) begin
      @(negedge clk);
      if (!berr_n) begin be = 1; done = 1; end
      else if (!sterm_n) begin
        if (lows == 0) rv = rdata;
        lows++;
      end else if (lows != 0) done = 1;
    end
    as_n = 1'b1;
    if (!done) chk(1'b0, "R4", "access timed out", a, 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog: got hung run expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rv, exp_v, a;
    int lows, n0, f0, d, off, n;
    bit be;

    repeat (4) @(negedge clk);
    chk(sterm_n === 1'b1, "R4", "sterm in reset", {31'b0, sterm_n}, 32'h1);
    chk(berr_n === 1'b1, "R5", "berr in reset", {31'b0, berr_n}, 32'h1);
    chk(sd_cke === 1'b0, "R1", "cke in reset", {31'b0, sd_cke}, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 500 && !mrs_seen; k++) @(negedge clk);
    @(negedge clk);
    chk(first_cyc >= INIT && first_cyc <= INIT + 1, "R1", "power-up wait",
        32'(first_cyc), 32'(INIT));
    chk(h_cmd[0] == 3'b010 && h_a[0][10], "R1", "first cmd precharge-all",
        {29'b0, h_cmd[0]}, 32'h2);
    chk(h_cmd[1] == 3'b001, "R1", "second cmd refresh", {29'b0, h_cmd[1]}, 32'h1);
    chk(h_cmd[2] == 3'b001, "R1", "third cmd refresh", {29'b0, h_cmd[2]}, 32'h1);
    chk(h_cmd[3] == 3'b000 && h_a[3] == 11'h020, "R1", "mode load value",
        {18'b0, h_cmd[3], h_a[3]}, 32'h020);

    // full-longword writes over the whole array
    for (int i = 0; i < NLW; i++) begin
      ref_mem[i] = pat(i, 0);
      access(BASE + 32'(i * 4), 1'b0, 2'b00, ref_mem[i], rv, lows, be);
      chk(lows == 2 && !be, "R4", "write sterm width", 32'(lows), 32'h2);
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < NLW; i++)
      chk(mem[i] == ref_mem[i], "R7", "row/bank/col placement", mem[i], ref_mem[i]);

    // reads with every size code and offset return the whole longword
    for (int i = 0; i < NLW; i++) begin
      access(BASE + 32'(i * 4 + (i % 4)), 1'b1, 2'((i / 4) % 4), 32'h0, rv, lows, be);
      chk(rv == ref_mem[i], "R2", "full longword read", rv, ref_mem[i]);
      chk(lows == 2, "R4", "read sterm width", 32'(lows), 32'h2);
    end

    // byte-mask writes: every offset and size code
    for (int t = 0; t < 16; t++) begin
      for (int o = 0; o < 4; o++) begin
        for (int s = 0; s < 4; s++) begin
          int idx;
          idx = (t * 37 + o * 5 + s) % NLW;
          wdata = pat(idx, t * 16 + o * 4 + s + 1);
          exp_v = ref_mem[idx];
          n = (s == 0) ? 4 : s;
          for (int k = 0; k < 4; k++)
            if (k >= o && k < o + n) exp_v[31-8*k -: 8] = wdata[31-8*k -: 8];
          ref_mem[idx] = exp_v;
          access(BASE + 32'(idx * 4 + o), 1'b0, 2'(s), wdata, rv, lows, be);
          access(BASE + 32'(idx * 4), 1'b1, 2'b00, 32'h0, rv, lows, be);
          chk(rv == exp_v, "R3", "masked write", rv, exp_v);
        end
      end
    end

    // unpopulated part of the window: local bus error
    for (int j = 0; j < 2; j++) begin
      a = (j == 0) ? BASE + 32'h400 : BASE + 32'hFFC;
      n0 = n_act; f0 = st_falls; be = 0;
      @(negedge clk); addr = a; rw = 1'b1; siz = 2'b00; as_n = 1'b0;
      for (int k = 0; k < 40 && !be; k++) begin
        @(negedge clk);
        if (!berr_n) be = 1;
      end
      chk(be, "R5", "bus error raised", {31'b0, be}, 32'h1);
      repeat (6) @(negedge clk);
      chk(berr_n === 1'b0, "R5", "bus error held", {31'b0, berr_n}, 32'h0);
      as_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(berr_n === 1'b1, "R5", "bus error released", {31'b0, berr_n}, 32'h1);
      chk(n_act == n0 && st_falls == f0, "R5", "no sdram access on error",
          32'(n_act - n0 + st_falls - f0), 32'h0);
    end

    // outside the window: ignored
    for (int j = 0; j < 3; j++) begin
      a = (j == 0) ? 32'h0200_0000 : (j == 1) ? BASE - 32'h4 : BASE + 32'h1000;
      n0 = n_act; f0 = st_falls; be = 0;
      @(negedge clk); addr = a; rw = 1'b1; as_n = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!berr_n) be = 1;
      end
      as_n = 1'b1;
      chk(!be && n_act == n0 && st_falls == f0, "R6", "outside window ignored",
          32'(n_act - n0 + st_falls - f0 + int'(be)), 32'h0);
    end

    // strobe held low after termination: one transaction only
    n0 = n_act; f0 = st_falls;
    @(negedge clk); addr = BASE + 32'h10; rw = 1'b1; siz = 2'b00; as_n = 1'b0;
    repeat (60) @(negedge clk);
    as_n = 1'b1;
    chk(n_act - n0 == 1, "R9", "activates per strobe", 32'(n_act - n0), 32'h1);
    chk(st_falls - f0 == 1, "R9", "terminations per strobe", 32'(st_falls - f0), 32'h1);

    // refresh rate while idle
    repeat (4) @(negedge clk);
    n0 = n_ref;
    repeat (RINT * 10) @(negedge clk);
    d = n_ref - n0;
    chk(d >= 9 && d <= 11, "R8", "refresh count in idle window", 32'(d), 32'd10);

    // protocol and final readback after refresh traffic
    for (int i = 0; i < NLW; i += 17) begin
      access(BASE + 32'(i * 4), 1'b1, 2'b01, 32'h0, rv, lows, be);
      chk(rv == ref_mem[i], "R8", "data kept across refreshes", rv, ref_mem[i]);
    end
    off = proto_err;
    chk(off == 0, "R7", "closed-page protocol violations", 32'(off), 32'h0);
    chk(n_ref > 20, "R8", "refreshes issued during run", 32'(n_ref), 32'd21);

    finished = 1;
    finish_run();
  end

endmodule